// File: doc/BRIEF.md
# NAND Flash Bus Sequencer

This block sits between a register port and an 8-bit raw NAND flash bus. Software writes command bytes, address bytes and write data into registers. Each write lands in a short write buffer. A strobe engine then drains the buffer, one bus cycle per entry. A command entry drives the command-latch line, and an address entry drives the address-latch line. The engine holds chip enable low for the whole cycle. It drives the byte one cycle before the strobe falls and keeps it stable until after the strobe rises.

Reading a single byte takes two steps. Software first writes any value to the read-request register. Once the device reports ready, the engine issues one read strobe and captures the byte. A read-ready flag then rises, and software collects the byte from the read-data register.

For whole pages, software writes the page-control register. The engine then runs 256 or 512 back-to-back read or write strobes, counted by a page byte counter. Read bytes leave on a one-cycle output stream. Write bytes are taken from an input stream that can stall. Interrupt-status bits clear when software writes one to them. A mask register selects which of them drive the single interrupt line.

Top module: `nand_bus_seq`

## Requirements
- R1: After reset the bus is idle: nand_ce_n, nand_we_n and nand_re_n are 1, and nand_cle and nand_ale are 0. Control (address 0) reads 0, interrupt status (address 2) reads 0, the interrupt mask (address 3) reads 7 (all masked), and irq_o is 0.
- R2: A write to address 4 produces one write strobe with nand_cle=1 and nand_ale=0. A write to address 5 produces one with nand_ale=1 and nand_cle=0. A write to address 6 produces one with both latches low. In every case nand_dout carries reg_wdata[7:0], and the latch lines and data are stable at the falling edge of the strobe.
- R3: A write strobe stays low for wr_dly+1 cycles and a read strobe for rd_dly+1 cycles. The control register holds the page-size bit at bit 0, the bus-width bit at bit 1, rd_dly at bits 6:2 and wr_dly at bits 11:7. Each strobe rise is followed by at least one cycle with both strobes high, and chip enable is low whenever a strobe is low.
- R4: The write buffer issues its entries in the order they were written. Status bit 0 (address 1) reads 1 while the buffer holds WBUF_DEPTH entries, and a register write that arrives while the buffer is full is dropped.
- R5: Any write to address 7 queues a single-byte read. The byte sampled from nand_din appears at address 8, and interrupt-status bit 1 sets.
- R6: A queued single-byte read waits, issuing no read strobe and leaving address 8 unchanged, while interrupt-status bit 1 is still set. It proceeds once that bit is cleared.
- R7: Writing to address 2 clears exactly the status bits written as one. Bits written as zero keep their value.
- R8: Interrupt-status bit 0 sets when nand_rb rises, seen after a two-flop synchronizer. Read strobes are not issued while the synchronized nand_rb is low.
- R9: irq_o is 1 exactly when some interrupt-status bit is set and its mask bit (address 3) is 0.
- R10: Writing 1 to address 9 starts a page read of 256 bytes, or of 512 bytes when control bit 0 is 1. Each byte is presented once on pg_out_data with pg_out_valid. Interrupt-status bit 2 sets when the page completes.
- R11: Writing 2 to address 9 starts a page write. Each byte is taken from pg_in_data in a cycle where pg_in_valid and pg_in_ready are both 1, and is driven with a write strobe. Interrupt-status bit 2 sets after the last byte.
- R12: A write to address 10 clears the page byte counter. A page started without that clear, after a finished page, issues no strobes and sets interrupt-status bit 2 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 12 | Register write data |
| reg_rdata | output | 12 | Register read data for reg_addr |
| irq_o | output | 1 | Masked interrupt |
| pg_in_valid | input | 1 | Page-write byte available |
| pg_in_data | input | 8 | Page-write byte |
| pg_in_ready | output | 1 | Page-write byte taken this cycle |
| pg_out_valid | output | 1 | Page-read byte valid (one cycle) |
| pg_out_data | output | 8 | Page-read byte |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dout | output | 8 | Bus data driven to the device |
| nand_doe | output | 1 | Bus output enable |
| nand_din | input | 8 | Bus data from the device |
| nand_rb | input | 1 | Ready/busy from the device, 1 = ready |

## Verification
The bench fills the write buffer while one long strobe is in progress and then pushes one more entry. A design with a wrong full threshold would either reorder or lose an entry, or let the extra write through. It issues a second read request while the read-ready flag is still set. A design that ignores the hold would overwrite the first byte. It holds ready/busy low across a read request, which a design that does not gate on it would strobe straight through. It also restarts a page without clearing the counter. A design that restarts the counter on its own would move a second full page where none is expected. Strobe widths are measured at both a short and a long delay setting to expose off-by-one pulse lengths.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

    localparam int unsigned DLY_W = 5;
    localparam int unsigned REG_W = 2 + 2 * DLY_W;
    localparam int unsigned IRQ_W = 3;

    localparam int unsigned IRQ_RB = 0;
    localparam int unsigned IRQ_RD = 1;
    localparam int unsigned IRQ_PG = 2;

    localparam logic [3:0] A_CTRL   = 4'd0;
    localparam logic [3:0] A_STATUS = 4'd1;
    localparam logic [3:0] A_ISTAT  = 4'd2;
    localparam logic [3:0] A_IMASK  = 4'd3;
    localparam logic [3:0] A_CMD    = 4'd4;
    localparam logic [3:0] A_ADDR   = 4'd5;
    localparam logic [3:0] A_WDATA  = 4'd6;
    localparam logic [3:0] A_RDREQ  = 4'd7;
    localparam logic [3:0] A_RDDATA = 4'd8;
    localparam logic [3:0] A_PGCTL  = 4'd9;
    localparam logic [3:0] A_PGRST  = 4'd10;

    typedef enum logic [1:0] {
        OP_CMD   = 2'd0,
        OP_ADDR  = 2'd1,
        OP_WDATA = 2'd2,
        OP_RDATA = 2'd3
    } nbs_op_e;

    typedef struct packed {
        nbs_op_e    op;
        logic [7:0] val;
    } nbs_req_t;

    typedef struct packed {
        logic [DLY_W-1:0] wr_dly;
        logic [DLY_W-1:0] rd_dly;
        logic             wide;
        logic             big_page;
    } nbs_ctrl_t;

    typedef enum logic [1:0] {
        EN_IDLE,
        EN_SETUP,
        EN_PULSE,
        EN_GAP
    } nbs_eng_e;

    typedef enum logic [1:0] {
        PG_NONE,
        PG_READ,
        PG_WRITE
    } nbs_pg_e;

    function automatic logic op_is_read(nbs_op_e op);
        return op == OP_RDATA;
    endfunction

endpackage

// File: rtl/nbs_wbuf.sv
module nbs_wbuf
    import nbs_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  nbs_req_t push_req,
    input  logic     pop,
    output nbs_req_t head,
    output logic     empty,
    output logic     full
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    nbs_req_t         slots [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [CNT_W-1:0] cnt;
    logic             do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = slots[rp];

    always_ff @(posedge clk) begin
        if (do_push) begin
            slots[wp] <= push_req;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) begin
                wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (do_pop) begin
                rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
            end
            if (do_push && !do_pop) begin
                cnt <= cnt + 1'b1;
            end else if (do_pop && !do_push) begin
                cnt <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/nbs_rb_sync.sv
module nbs_rb_sync (
    input  logic clk,
    input  logic rst,
    input  logic rb_in,
    output logic rb_lvl,
    output logic rb_rise
);
    logic [1:0] sync_q;
    logic       prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b11;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], rb_in};
            prev_q <= sync_q[1];
        end
    end

    assign rb_lvl  = sync_q[1];
    assign rb_rise = sync_q[1] && !prev_q;
endmodule

// File: rtl/nbs_strobe.sv
module nbs_strobe
    import nbs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  nbs_req_t         req,
    input  logic             rb_ok,
    input  logic [DLY_W-1:0] rd_dly,
    input  logic [DLY_W-1:0] wr_dly,
    output logic             taken,
    output logic             idle,
    output logic             cap_valid,
    output logic [7:0]       cap_data,
    input  logic [7:0]       nand_din,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [7:0]       nand_dout,
    output logic             nand_doe
);
    nbs_eng_e         state_q;
    nbs_req_t         cur_q;
    logic [DLY_W-1:0] cnt_q;
    logic             cur_rd, active;

    assign cur_rd = op_is_read(cur_q.op);
    assign idle   = (state_q == EN_IDLE);
    assign taken  = idle && req_valid && (!op_is_read(req.op) || rb_ok);
    assign active = !idle;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= EN_IDLE;
            cur_q     <= '0;
            cnt_q     <= '0;
            cap_valid <= 1'b0;
            cap_data  <= '0;
        end else begin
            cap_valid <= 1'b0;
            unique case (state_q)
                EN_IDLE: begin
                    if (taken) begin
                        cur_q   <= req;
                        state_q <= EN_SETUP;
                    end
                end
                EN_SETUP: begin
                    cnt_q   <= cur_rd ? rd_dly : wr_dly;
                    state_q <= EN_PULSE;
                end
                EN_PULSE: begin
                    if (cnt_q == '0) begin
                        state_q <= EN_GAP;
                        if (cur_rd) begin
                            cap_valid <= 1'b1;
                            cap_data  <= nand_din;
                        end
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                EN_GAP: state_q <= EN_IDLE;
                default: state_q <= EN_IDLE;
            endcase
        end
    end

    assign nand_ce_n = !active;
    assign nand_cle  = active && (cur_q.op == OP_CMD);
    assign nand_ale  = active && (cur_q.op == OP_ADDR);
    assign nand_we_n = !((state_q == EN_PULSE) && !cur_rd);
    assign nand_re_n = !((state_q == EN_PULSE) && cur_rd);
    assign nand_dout = cur_q.val;
    assign nand_doe  = active && !cur_rd;
endmodule

// File: rtl/nand_bus_seq.sv
module nand_bus_seq
    import nbs_pkg::*;
#(
    parameter int unsigned WBUF_DEPTH = 4,
    parameter int unsigned PAGE_SMALL = 256,
    parameter int unsigned PAGE_LARGE = 512
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [3:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq_o,
    input  logic             pg_in_valid,
    input  logic [7:0]       pg_in_data,
    output logic             pg_in_ready,
    output logic             pg_out_valid,
    output logic [7:0]       pg_out_data,
    output logic             nand_ce_n,
    output logic             nand_cle,
    output logic             nand_ale,
    output logic             nand_we_n,
    output logic             nand_re_n,
    output logic [7:0]       nand_dout,
    output logic             nand_doe,
    input  logic [7:0]       nand_din,
    input  logic             nand_rb
);
    localparam int unsigned CNT_W = $clog2(PAGE_LARGE + 1);

    nbs_ctrl_t        ctrl_q;
    logic [IRQ_W-1:0] mask_q, irq_q, irq_set, irq_clr;
    logic [7:0]       rd_data_q;
    nbs_pg_e          pg_mode_q;
    logic [CNT_W-1:0] pg_cnt_q, page_len;
    logic             cur_page_q;

    logic     wb_push, wb_pop, wb_empty, wb_full;
    nbs_req_t wb_in, wb_head;
    logic     eng_req_valid, eng_taken, eng_idle, cap_valid;
    nbs_req_t eng_req;
    logic [7:0] cap_data;
    logic     rb_lvl, rb_rise, pg_take, pg_finish, is_queue_addr;

    assign page_len = ctrl_q.big_page ? CNT_W'(PAGE_LARGE) : CNT_W'(PAGE_SMALL);

    // register writes that become bus cycles
    always_comb begin
        is_queue_addr = 1'b1;
        wb_in.val     = reg_wdata[7:0];
        unique case (reg_addr)
            A_CMD:   wb_in.op = OP_CMD;
            A_ADDR:  wb_in.op = OP_ADDR;
            A_WDATA: wb_in.op = OP_WDATA;
            A_RDREQ: wb_in.op = OP_RDATA;
            default: begin
                wb_in.op      = OP_CMD;
                is_queue_addr = 1'b0;
            end
        endcase
    end
    assign wb_push = reg_wr && is_queue_addr && !wb_full;

    nbs_wbuf #(.DEPTH(WBUF_DEPTH)) u_wbuf (
        .clk      (clk),
        .rst      (rst),
        .push     (wb_push),
        .push_req (wb_in),
        .pop      (wb_pop),
        .head     (wb_head),
        .empty    (wb_empty),
        .full     (wb_full)
    );

    nbs_rb_sync u_rb (
        .clk     (clk),
        .rst     (rst),
        .rb_in   (nand_rb),
        .rb_lvl  (rb_lvl),
        .rb_rise (rb_rise)
    );

    // request selection: queued entries first, then page traffic
    always_comb begin
        eng_req       = wb_head;
        eng_req_valid = 1'b0;
        if (!wb_empty) begin
            eng_req_valid = !((wb_head.op == OP_RDATA) && irq_q[IRQ_RD]);
        end else if ((pg_mode_q != PG_NONE) && (pg_cnt_q != page_len)) begin
            if (pg_mode_q == PG_READ) begin
                eng_req.op    = OP_RDATA;
                eng_req.val   = '0;
                eng_req_valid = 1'b1;
            end else begin
                eng_req.op    = OP_WDATA;
                eng_req.val   = pg_in_data;
                eng_req_valid = pg_in_valid;
            end
        end
    end

    nbs_strobe u_eng (
        .clk       (clk),
        .rst       (rst),
        .req_valid (eng_req_valid),
        .req       (eng_req),
        .rb_ok     (rb_lvl),
        .rd_dly    (ctrl_q.rd_dly),
        .wr_dly    (ctrl_q.wr_dly),
        .taken     (eng_taken),
        .idle      (eng_idle),
        .cap_valid (cap_valid),
        .cap_data  (cap_data),
        .nand_din  (nand_din),
        .nand_ce_n (nand_ce_n),
        .nand_cle  (nand_cle),
        .nand_ale  (nand_ale),
        .nand_we_n (nand_we_n),
        .nand_re_n (nand_re_n),
        .nand_dout (nand_dout),
        .nand_doe  (nand_doe)
    );

    assign wb_pop       = eng_taken && !wb_empty;
    assign pg_take      = eng_taken && wb_empty;
    assign pg_in_ready  = pg_take && (pg_mode_q == PG_WRITE);
    assign pg_out_valid = cap_valid && cur_page_q;
    assign pg_out_data  = cap_data;
    assign pg_finish    = (pg_mode_q != PG_NONE) && (pg_cnt_q == page_len)
                          && eng_idle && wb_empty;

    assign irq_clr = (reg_wr && reg_addr == A_ISTAT) ? reg_wdata[IRQ_W-1:0] : '0;
    always_comb begin
        irq_set         = '0;
        irq_set[IRQ_RB] = rb_rise;
        irq_set[IRQ_RD] = cap_valid && !cur_page_q;
        irq_set[IRQ_PG] = pg_finish;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            mask_q     <= '1;
            irq_q      <= '0;
            rd_data_q  <= '0;
            pg_mode_q  <= PG_NONE;
            pg_cnt_q   <= '0;
            cur_page_q <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == A_CTRL) begin
                ctrl_q <= nbs_ctrl_t'(reg_wdata);
            end
            if (reg_wr && reg_addr == A_IMASK) begin
                mask_q <= reg_wdata[IRQ_W-1:0];
            end
            irq_q <= (irq_q & ~irq_clr) | irq_set;
            if (eng_taken) begin
                cur_page_q <= wb_empty;
            end
            if (cap_valid && !cur_page_q) begin
                rd_data_q <= cap_data;
            end
            if (reg_wr && reg_addr == A_PGRST) begin
                pg_cnt_q <= '0;
            end else if (pg_take) begin
                pg_cnt_q <= pg_cnt_q + 1'b1;
            end
            if (pg_finish) begin
                pg_mode_q <= PG_NONE;
            end else if (reg_wr && reg_addr == A_PGCTL && pg_mode_q == PG_NONE) begin
                if (reg_wdata == REG_W'(1)) begin
                    pg_mode_q <= PG_READ;
                end else if (reg_wdata == REG_W'(2)) begin
                    pg_mode_q <= PG_WRITE;
                end
            end
        end
    end

    assign irq_o = |(irq_q & ~mask_q);

    always_comb begin
        unique case (reg_addr)
            A_CTRL:   reg_rdata = ctrl_q;
            A_STATUS: reg_rdata = REG_W'({rb_lvl, !(eng_idle && wb_empty),
                                          pg_mode_q != PG_NONE, wb_full});
            A_ISTAT:  reg_rdata = REG_W'(irq_q);
            A_IMASK:  reg_rdata = REG_W'(mask_q);
            A_RDDATA: reg_rdata = REG_W'(rd_data_q);
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/nbs_chk.sv
module nbs_chk (
    input logic       clk,
    input logic       rst,
    input logic       nand_ce_n,
    input logic       nand_cle,
    input logic       nand_ale,
    input logic       nand_we_n,
    input logic       nand_re_n,
    input logic [7:0] nand_dout,
    input logic       pg_in_valid,
    input logic       pg_in_ready
);
    // R2
    latch_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(nand_cle && nand_ale));

    // R2
    setup_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(nand_we_n) |-> ($stable(nand_cle) && $stable(nand_ale) && $stable(nand_dout)));

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!nand_we_n && !nand_re_n));

    // R3
    strobe_ce_chk: assert property (@(posedge clk) disable iff (rst)
        (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

    // R3
    we_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(nand_we_n) |=> (nand_we_n && nand_re_n));

    // R3
    re_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(nand_re_n) |=> (nand_we_n && nand_re_n));

    // R11
    pg_ready_chk: assert property (@(posedge clk) disable iff (rst)
        pg_in_ready |-> pg_in_valid);
endmodule

bind nand_bus_seq nbs_chk i_chk (.*);

// File: tb/test_nand_bus_seq.sv
module test_nand_bus_seq;
    localparam int REG_W = 12;
    localparam int WATCHDOG = 150000;

    function automatic logic [7:0] rpat(int i);
        return 8'((i * 37 + 11) & 255);
    endfunction
    function automatic logic [7:0] wpat(int i);
        return 8'((i * 13 + 5) & 255);
    endfunction

    logic clk = 0, rst = 1;
    logic reg_wr = 0;
    logic [3:0] reg_addr = 0;
    logic [REG_W-1:0] reg_wdata = 0, reg_rdata;
    logic irq_o, pg_in_valid = 0, pg_in_ready, pg_out_valid;
    logic [7:0] pg_in_data, pg_out_data, nand_dout, nand_din;
    logic nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_doe;
    logic nand_rb = 1;

    int checks = 0, fails = 0, cyc = 0;
    int rd_idx = 0, wr_idx = 0;
    int ev_n = 0, out_n = 0, run = 0, hi_run = 0, min_gap = 1000;
    int ev_kind [4096];
    int ev_byte [4096];
    int ev_w    [4096];
    logic [7:0] out_log [4096];
    logic prev_low = 0, prev_re = 1, ev_cle = 0, ev_ale = 0;
    logic [7:0] ev_d = 0;

    assign nand_din   = rpat(rd_idx);
    assign pg_in_data = wpat(wr_idx);

    always #2 clk = ~clk;

    nand_bus_seq i_nand_bus_seq (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o),
        .pg_in_valid(pg_in_valid), .pg_in_data(pg_in_data), .pg_in_ready(pg_in_ready),
        .pg_out_valid(pg_out_valid), .pg_out_data(pg_out_data),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dout(nand_dout),
        .nand_doe(nand_doe), .nand_din(nand_din), .nand_rb(nand_rb)
    );

    // bus monitor: kinds 1=command 2=address 3=data write 4=data read
    always @(negedge clk) begin
        logic low;
        low = !nand_we_n || !nand_re_n;
        if (low) begin
            if (!prev_low && ev_n > 0 && hi_run < min_gap) min_gap = hi_run;
            run++;
            ev_cle = nand_cle; ev_ale = nand_ale; ev_d = nand_dout;
        end else begin
            hi_run++;
            if (prev_low) begin
                ev_kind[ev_n] = ev_cle ? 1 : ev_ale ? 2 : (!prev_re ? 4 : 3);
                ev_byte[ev_n] = ev_d;
                ev_w[ev_n]    = run;
                ev_n++;
                run = 0;
                hi_run = 1;
            end
        end
        if (!prev_re && nand_re_n) rd_idx++;
        prev_re  = nand_re_n;
        prev_low = low;
        if (pg_out_valid) begin
            out_log[out_n] = pg_out_data;
            out_n++;
        end
    end

    always @(posedge clk) if (pg_in_valid && pg_in_ready) wr_idx <= wr_idx + 1;

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input int d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = REG_W'(d);
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output int d);
        @(negedge clk);
        reg_addr = a;
        #1 d = int'(reg_rdata);
    endtask

    task automatic wait_idle();
        int s;
        for (int i = 0; i < 20000; i++) begin
            rd(4'd1, s);
            if (s[2] == 0) break;
        end
    endtask

    task automatic wait_irq(input int bitn, output logic seen);
        int s;
        seen = 0;
        for (int i = 0; i < 6000; i++) begin
            rd(4'd2, s);
            if (s[bitn]) begin seen = 1; break; end
        end
    endtask

    task automatic t_reset();
        int v;
        check(nand_ce_n && nand_we_n && nand_re_n && !nand_cle && !nand_ale,
              "R1 bus idle", {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale}, 5'b11100);
        rd(4'd0, v); check(v == 0, "R1 control", v, 0);
        rd(4'd2, v); check(v == 0, "R1 irq status", v, 0);
        rd(4'd3, v); check(v == 7, "R1 mask", v, 7);
        check(irq_o == 0, "R1 irq_o", irq_o, 0);
    endtask

    task automatic t_cmd_addr();
        int base;
        wr(4'd0, 2 << 7);
        base = ev_n;
        wr(4'd4, 8'h90); wr(4'd5, 8'h3C); wr(4'd6, 8'h5A);
        wait_idle();
        check(ev_n - base == 3, "R2 strobe count", ev_n - base, 3);
        check(ev_kind[base] == 1 && ev_byte[base] == 8'h90, "R2 command cycle",
              ev_kind[base] * 256 + ev_byte[base], 256 + 8'h90);
        check(ev_kind[base+1] == 2 && ev_byte[base+1] == 8'h3C, "R2 address cycle",
              ev_kind[base+1] * 256 + ev_byte[base+1], 512 + 8'h3C);
        check(ev_kind[base+2] == 3 && ev_byte[base+2] == 8'h5A, "R2 data cycle",
              ev_kind[base+2] * 256 + ev_byte[base+2], 768 + 8'h5A);
        check(ev_w[base] == 3 && ev_w[base+2] == 3, "R3 write width wr_dly=2", ev_w[base], 3);
        check(min_gap >= 1, "R3 gap between strobes", min_gap, 1);
    endtask

    task automatic t_fifo();
        int base, s, bad;
        wr(4'd0, 15 << 7);
        base = ev_n;
        for (int i = 0; i < 5; i++) wr(4'd4, 8'hA0 + i);
        rd(4'd1, s);
        check(s[0] == 1, "R4 buffer full flag", s[0], 1);
        wr(4'd4, 8'hEE);
        wait_idle();
        check(ev_n - base == 5, "R4 full write dropped", ev_n - base, 5);
        bad = 0;
        for (int i = 0; i < 5; i++) if (ev_byte[base+i] != 8'hA0 + i) bad++;
        check(bad == 0, "R4 issue order", bad, 0);
        check(ev_w[base] == 16, "R3 write width wr_dly=15", ev_w[base], 16);
        rd(4'd1, s);
        check(s[0] == 0, "R4 full flag clears", s[0], 0);
    endtask

    task automatic t_read();
        int base, v, i0;
        logic seen;
        wr(4'd0, 1 << 2);
        i0 = rd_idx; base = ev_n;
        wr(4'd7, 0);
        wait_irq(1, seen);
        check(seen, "R5 read-ready sets", seen, 1);
        rd(4'd8, v);
        check(v == rpat(i0), "R5 read data", v, rpat(i0));
        check(ev_kind[base] == 4 && ev_w[base] == 2, "R3 read width rd_dly=1", ev_w[base], 2);
        base = ev_n;
        wr(4'd7, 12'h123);
        repeat (40) @(negedge clk);
        check(ev_n == base, "R6 read held while flag set", ev_n - base, 0);
        rd(4'd8, v);
        check(v == rpat(i0), "R6 data kept", v, rpat(i0));
        wr(4'd2, 2);
        wait_irq(1, seen);
        rd(4'd8, v);
        check(seen && v == rpat(i0 + 1), "R6 read resumes", v, rpat(i0 + 1));
        wr(4'd2, 2);
    endtask

    task automatic t_rb_irq();
        int base, v;
        logic seen;
        nand_rb = 0;
        repeat (4) @(negedge clk);
        base = ev_n;
        wr(4'd7, 0);
        repeat (20) @(negedge clk);
        check(ev_n == base, "R8 no read while busy", ev_n - base, 0);
        nand_rb = 1;
        wait_irq(1, seen);
        rd(4'd2, v);
        check(v == 3, "R8 ready and read flags", v, 3);
        check(irq_o == 0, "R9 all masked", irq_o, 0);
        wr(4'd3, 5);
        @(negedge clk);
        check(irq_o == 1, "R9 unmasked bit drives irq", irq_o, 1);
        wr(4'd3, 6);
        @(negedge clk);
        check(irq_o == 1, "R9 other unmasked bit", irq_o, 1);
        wr(4'd2, 1);
        rd(4'd2, v);
        check(v == 2, "R7 clear one bit only", v, 2);
        @(negedge clk);
        check(irq_o == 0, "R9 masked remaining bit", irq_o, 0);
        wr(4'd2, 2);
        rd(4'd2, v);
        check(v == 0, "R7 clear second bit", v, 0);
        wr(4'd3, 7);
    endtask

    task automatic t_page_read(input int big, input int len);
        int base, ob, i0, bad;
        logic seen;
        wr(4'd0, big);
        wr(4'd10, 0);
        base = ev_n; ob = out_n; i0 = rd_idx;
        wr(4'd9, 1);
        wait_irq(2, seen);
        check(seen, "R10 page done flag", seen, 1);
        check(out_n - ob == len, "R10 page byte count", out_n - ob, len);
        check(ev_n - base == len, "R10 read strobe count", ev_n - base, len);
        bad = 0;
        for (int i = 0; i < len; i++) if (out_log[ob+i] != rpat(i0 + i)) bad++;
        check(bad == 0, "R10 page bytes", bad, 0);
        wr(4'd2, 4);
    endtask

    task automatic t_no_reset();
        int base, v;
        logic seen;
        base = ev_n;
        wr(4'd9, 1);
        wait_irq(2, seen);
        check(seen && ev_n == base, "R12 restart without counter clear", ev_n - base, 0);
        wr(4'd2, 4);
        rd(4'd2, v);
        check(v == 0, "R7 page flag cleared", v, 0);
    endtask

    task automatic t_page_write();
        int base, w0, bad;
        logic seen;
        wr(4'd0, 0);
        wr(4'd10, 0);
        base = ev_n; w0 = wr_idx;
        pg_in_valid = 1;
        wr(4'd9, 2);
        wait_irq(2, seen);
        pg_in_valid = 0;
        check(seen, "R11 page write done", seen, 1);
        check(wr_idx - w0 == 256, "R11 bytes taken", wr_idx - w0, 256);
        check(ev_n - base == 256, "R11 write strobes", ev_n - base, 256);
        bad = 0;
        for (int i = 0; i < 256; i++)
            if (ev_kind[base+i] != 3 || ev_byte[base+i] != wpat(w0 + i)) bad++;
        check(bad == 0, "R11 bytes on bus", bad, 0);
        wr(4'd2, 4);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            fails++;
            $display("FAIL watchdog (all requirements) actual=%0d expected<%0d", cyc, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst = 0;
        repeat (3) @(negedge clk);
        t_cmd_addr();
        t_fifo();
        t_read();
        t_rb_irq();
        t_page_read(0, 256);
        t_no_reset();
        t_page_read(1, 512);
        t_page_write();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule